// File: doc/BRIEF.md
# VPW Byte-Level Transmit Sequencer

This block drives one node's frames onto a single-wire variable-pulse-width serial bus. It holds no message buffer. The CPU hands over bytes one at a time through a holding register that sits in front of a shift register. When the CPU writes the first byte while the block is idle, a frame starts. The block then waits until the bus has been passive long enough, sends a start symbol, and serialises the bytes most-significant bit first. It asks for each following byte through a transmit-data-register-empty flag and a masked interrupt.

After the final byte, the CPU sets a single end-of-data bit. The block then appends an inverted CRC-8 over all data bytes and closes the frame with a long passive end symbol. It clears the end-of-data bit at the moment the first CRC bit starts to drive.

The bus is wired-OR, and a high level is dominant. During every bit, the block compares the level it drives with the level it reads back. It aborts at once if another node wins arbitration or if the bus fails to follow its own drive. A read of the data register returns the last byte that completed on the bus, never a byte the CPU wrote. All symbol durations are parameters given in clock ticks.

Top module: `j1850_tx_seq`

## Requirements
- R1: After synchronous reset, bus_out is 0 (passive), tdre is 1, eod_bit is 0, and busy, arb_lost, tx_fault and tdre_irq are 0.
- R2: A write while idle starts a frame with that byte; there is no other start command. The start symbol, bus_out=1 for SOF_T cycles, begins only after bus_in has been 0 for IDLE_T consecutive cycles: IDLE_T+1 cycles after a dominant bus is released.
- R3: After the start symbol, each bit is one phase. Phases alternate passive (even bit index within the byte, counted from the MSB) and active (odd index), and bytes go MSB first. A passive phase lasts LONG_T cycles for a 1 and SHORT_T cycles for a 0. An active phase lasts LONG_T cycles for a 0 and SHORT_T cycles for a 1.
- R4: tdre falls on an accepted write and rises when the held byte moves into the shifter. A write while tdre is 0 is ignored and changes no transmitted byte.
- R5: tdre_irq is 1 only when tdre is 1, a frame is active and eod_bit is 0. While eod_bit is set, tdre_irq stays 0.
- R6: Once the last byte ends with eod_bit set, the block sends one byte equal to the bitwise inverse of a CRC-8. The CRC uses polynomial 0x1D and initial value 0xFF, taken MSB first over every data byte of the frame. The block then holds bus_out=0 for EOD_T cycles, after which busy falls.
- R7: eod_bit clears in the same cycle that the first CRC bit starts. A set request while idle is ignored.
- R8: If bus_in is 1 while the block drives passive during a bit, the block stops in the next cycle. It then has bus_out=0, busy=0, arb_lost=1, eod_bit=0 and tdre=1.
- R9: If bus_in is 0 while the block drives the start symbol or an active bit, or if a byte ends with no held byte and eod_bit clear, the block aborts with tx_fault=1 and busy=0.
- R10: rd_data holds the last byte that completed on the bus. After a full frame it equals the CRC byte, and writes never change it.
- R11: Frame length is not limited. A 20-byte frame completes with the correct waveform and CRC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe to the data register |
| wr_data | input | 8 | Byte written by the CPU |
| eod_set | input | 1 | Request to set the end-of-data bit |
| rd_data | output | 8 | Last byte completed on the bus |
| tdre | output | 1 | Holding register empty |
| tdre_irq | output | 1 | Interrupt request for the next byte |
| eod_bit | output | 1 | End-of-data control bit |
| busy | output | 1 | Frame in progress |
| arb_lost | output | 1 | Last frame lost arbitration |
| tx_fault | output | 1 | Last frame aborted on bus fault or underrun |
| bus_in | input | 1 | Sampled bus level, 1 = dominant |
| bus_out | output | 1 | Drive dominant when 1 |

## Verification
The hardest case to reach is the exact edge where the end-of-data bit clears together with the first CRC phase. It only occurs after the CPU has kept pace with TDRE across a whole random-length frame. The bench therefore feeds random frames by polling tdre. It counts the falling edges of bus_out and checks that eod_bit drops precisely at edge 4N+1. It also rebuilds every pulse width from the bytes and compares the result against the measured run lengths. Arbitration loss and drive faults are provoked by a wired-OR intruder and a forced-low bus that act at chosen phase edges.

// File: rtl/j1850_tx_pkg.sv
package j1850_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SOF,
    ST_DATA,
    ST_EOD
  } tx_state_e;
endpackage

// File: rtl/j1850_idle_mon.sv
module j1850_idle_mon #(
  parameter int IDLE_T = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_in,
  output logic bus_free
);
  localparam int IW = $clog2(IDLE_T + 1);

  logic [IW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (bus_in) begin
      run_q <= '0;
    end else if (run_q != IW'(IDLE_T)) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign bus_free = (run_q == IW'(IDLE_T));

  AST_FREE_NEEDS_QUIET: assert property (@(posedge clk) disable iff (rst)
    bus_in |=> !bus_free); // R2
endmodule

// File: rtl/j1850_crc8.sv
module j1850_crc8 #(
  parameter logic [7:0] POLY = 8'h1D,
  parameter logic [7:0] SEED = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       init,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc_byte
);
  logic [7:0] acc_q;

  function automatic logic [7:0] step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ POLY) : (r << 1);
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || init) begin
      acc_q <= SEED;
    end else if (en) begin
      acc_q <= step(acc_q, din);
    end
  end

  assign crc_byte = ~acc_q;
endmodule

// File: rtl/j1850_tx_seq.sv
module j1850_tx_seq
  import j1850_tx_pkg::*;
#(
  parameter int SHORT_T = 4,
  parameter int LONG_T  = 8,
  parameter int SOF_T   = 12,
  parameter int EOD_T   = 10,
  parameter int IDLE_T  = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       eod_set,
  output logic [7:0] rd_data,
  output logic       tdre,
  output logic       tdre_irq,
  output logic       eod_bit,
  output logic       busy,
  output logic       arb_lost,
  output logic       tx_fault,
  input  logic       bus_in,
  output logic       bus_out
);
  localparam int M1   = (LONG_T > SOF_T) ? LONG_T : SOF_T;
  localparam int MAXT = (M1 > EOD_T) ? M1 : EOD_T;
  localparam int CW   = $clog2(MAXT + 1);

  tx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    hold_q, sh_q, byte_q, rd_q;
  logic [2:0]    bit_q;
  logic          hold_full_q, eod_q, in_crc_q, bus_out_q, arb_q, flt_q;
  logic          bus_free;
  logic [7:0]    crc_byte;

  logic phase_end, start, abort_arb, abort_flt, byte_end;
  logic take_hold, send_crc, go_eod, underrun, wr_ok, eod_ok;
  logic [7:0] load_val;

  function automatic logic [CW-1:0] dur(input logic b, input logic act);
    return (b ^ act) ? CW'(LONG_T - 1) : CW'(SHORT_T - 1);
  endfunction

  j1850_idle_mon #(.IDLE_T(IDLE_T)) u_idle (
    .clk(clk), .rst(rst), .bus_in(bus_in), .bus_free(bus_free)
  );

  j1850_crc8 u_crc (
    .clk(clk), .rst(rst), .init(start), .en(take_hold),
    .din(hold_q), .crc_byte(crc_byte)
  );

  always_comb begin
    phase_end = (cnt_q == '0);
    start     = wr_en && (state_q == ST_IDLE);
    abort_arb = (state_q == ST_DATA) && !bus_out_q && bus_in;
    abort_flt = ((state_q == ST_DATA) && bus_out_q && !bus_in) ||
                ((state_q == ST_SOF) && !bus_in);
    byte_end  = (state_q == ST_DATA) && !abort_arb && !abort_flt &&
                phase_end && (bit_q == 3'd7);
    go_eod    = byte_end && in_crc_q;
    take_hold = hold_full_q && !in_crc_q &&
                (byte_end || ((state_q == ST_SOF) && !abort_flt && phase_end));
    send_crc  = byte_end && !in_crc_q && !hold_full_q && eod_q;
    underrun  = byte_end && !in_crc_q && !hold_full_q && !eod_q;
    load_val  = send_crc ? crc_byte : hold_q;
    eod_ok    = eod_set && !in_crc_q &&
                (state_q == ST_WAIT || state_q == ST_SOF || state_q == ST_DATA);
    wr_ok     = wr_en && !hold_full_q && !in_crc_q && !eod_q &&
                (state_q == ST_SOF || state_q == ST_DATA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      hold_q      <= '0;
      sh_q        <= '0;
      byte_q      <= '0;
      rd_q        <= '0;
      bit_q       <= '0;
      hold_full_q <= 1'b0;
      eod_q       <= 1'b0;
      in_crc_q    <= 1'b0;
      bus_out_q   <= 1'b0;
      arb_q       <= 1'b0;
      flt_q       <= 1'b0;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (wr_ok) begin
        hold_q      <= wr_data;
        hold_full_q <= 1'b1;
      end
      if (eod_ok) eod_q <= 1'b1;

      case (state_q)
        ST_IDLE: if (start) begin
          state_q     <= ST_WAIT;
          hold_q      <= wr_data;
          hold_full_q <= 1'b1;
          in_crc_q    <= 1'b0;
          eod_q       <= 1'b0;
          arb_q       <= 1'b0;
          flt_q       <= 1'b0;
        end
        ST_WAIT: if (bus_free) begin
          state_q   <= ST_SOF;
          bus_out_q <= 1'b1;
          cnt_q     <= CW'(SOF_T - 1);
        end
        ST_SOF, ST_DATA: begin
          if (abort_arb || abort_flt || underrun) begin
            state_q     <= ST_IDLE;
            bus_out_q   <= 1'b0;
            hold_full_q <= 1'b0;
            eod_q       <= 1'b0;
            in_crc_q    <= 1'b0;
            arb_q       <= abort_arb;
            flt_q       <= abort_flt || underrun;
          end else if (state_q == ST_DATA && phase_end) begin
            if (bit_q != 3'd7) begin
              bit_q     <= bit_q + 3'd1;
              sh_q      <= sh_q << 1;
              bus_out_q <= ~bus_out_q;
              cnt_q     <= dur(sh_q[6], ~bit_q[0]);
            end else begin
              rd_q <= byte_q;
              if (go_eod) begin
                state_q   <= ST_EOD;
                bus_out_q <= 1'b0;
                in_crc_q  <= 1'b0;
                cnt_q     <= CW'(EOD_T - 1);
              end
            end
          end
        end
        ST_EOD: if (phase_end) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase

      if (take_hold || send_crc) begin
        state_q   <= ST_DATA;
        sh_q      <= load_val;
        byte_q    <= load_val;
        bit_q     <= 3'd0;
        bus_out_q <= 1'b0;
        cnt_q     <= dur(load_val[7], 1'b0);
      end
      if (take_hold) hold_full_q <= 1'b0;
      if (send_crc) begin
        in_crc_q <= 1'b1;
        eod_q    <= 1'b0;
      end
    end
  end

  assign rd_data  = rd_q;
  assign tdre     = !hold_full_q;
  assign busy     = (state_q != ST_IDLE);
  assign tdre_irq = tdre && busy && !eod_q;
  assign eod_bit  = eod_q;
  assign arb_lost = arb_q;
  assign tx_fault = flt_q;
  assign bus_out  = bus_out_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !bus_out_q); // R1
  AST_WAIT_FOR_FREE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !bus_free) |=> (state_q != ST_SOF)); // R2
  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (hold_full_q && wr_en) |=> $stable(hold_q)); // R4
  AST_ARB_ABORT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA && !bus_out_q && bus_in) |=>
      (state_q == ST_IDLE && arb_q && !bus_out_q && !eod_q)); // R8
  AST_EOD_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(eod_q) |-> (in_crc_q || state_q == ST_IDLE)); // R7
endmodule

// File: tb/j1850_tx_seq_bench.sv
module j1850_tx_seq_bench;
  localparam int SHORT_T = 4, LONG_T = 8, SOF_T = 12, EOD_T = 10, IDLE_T = 14;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, wr_en = 1'b0, eod_set = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic tdre, tdre_irq, eod_bit, busy, arb_lost, tx_fault, bus_in, bus_out;
  logic intruder = 1'b0, force_low = 1'b0;

  assign bus_in = force_low ? 1'b0 : (bus_out | intruder);

  j1850_tx_seq #(.SHORT_T(SHORT_T), .LONG_T(LONG_T), .SOF_T(SOF_T),
                 .EOD_T(EOD_T), .IDLE_T(IDLE_T)) u_j1850_tx_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .eod_set(eod_set),
    .rd_data(rd_data), .tdre(tdre), .tdre_irq(tdre_irq), .eod_bit(eod_bit),
    .busy(busy), .arb_lost(arb_lost), .tx_fault(tx_fault),
    .bus_in(bus_in), .bus_out(bus_out)
  );

  int checks = 0, fails = 0;
  logic [7:0] msg [0:31];
  int exp_runs [0:511];
  int got [0:511];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor
  logic mon_en = 1'b0;
  bit started, cur_lvl, mon_done, eod_prev, eod_fall_ok;
  int cur_len, n_got, falls, eod_fall_idx, irq_viol, irq_seen;

  always @(negedge clk) begin
    if (!mon_en) begin
      started = 0; n_got = 0; falls = 0; eod_fall_ok = 0;
      irq_viol = 0; irq_seen = 0; mon_done = 0; eod_prev = 0; cur_len = 0;
    end else if (!mon_done) begin
      if (eod_bit && tdre_irq) irq_viol++;
      if (!eod_bit && tdre_irq) irq_seen++;
      if (!started) begin
        if (bus_out) begin started = 1; cur_lvl = 1; cur_len = 1; end
      end else if (!busy) begin
        if (n_got < 512) got[n_got] = cur_len;
        n_got++;
        mon_done = 1;
      end else if (bus_out == cur_lvl) begin
        cur_len++;
      end else begin
        if (n_got < 512) got[n_got] = cur_len;
        n_got++;
        cur_lvl = bus_out;
        cur_len = 1;
        if (!bus_out) begin
          falls++;
          if (falls == eod_fall_idx && eod_prev && !eod_bit) eod_fall_ok = 1;
        end
      end
      eod_prev = eod_bit;
    end
  end

  function automatic logic [7:0] ref_crc(input int n);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ msg[i];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h1D) : (c << 1);
    end
    return ~c;
  endfunction

  function automatic int ref_len(input bit b, input bit act);
    return (b ^ act) ? LONG_T : SHORT_T;
  endfunction

  function automatic int build_exp(input int n);
    int k = 0;
    logic [7:0] b;
    exp_runs[k++] = SOF_T;
    for (int i = 0; i <= n; i++) begin
      b = (i == n) ? ref_crc(n) : msg[i];
      for (int j = 7; j >= 0; j--) exp_runs[k++] = ref_len(b[j], ((7 - j) % 2) == 1);
    end
    exp_runs[k++] = EOD_T;
    return k;
  endfunction

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_eod();
    @(negedge clk); eod_set = 1'b1;
    @(negedge clk); eod_set = 1'b0;
  endtask

  task automatic feed(input int n, input bit do_eod);
    wr(msg[0]);
    for (int i = 1; i < n; i++) begin
      while (!tdre) @(negedge clk);
      wr(msg[i]);
    end
    if (do_eod) pulse_eod();
  endtask

  task automatic check_frame(input int n, input string tag);
    int ne;
    int bad;
    ne = build_exp(n);
    bad = -1;
    for (int i = 0; i < ne; i++) if (bad < 0 && got[i] != exp_runs[i]) bad = i;
    chk(n_got == ne, "R3", {tag, " run count"}, n_got, ne);
    if (bad >= 0) chk(0, "R3/R6", {tag, " pulse width"}, got[bad], exp_runs[bad]);
    else chk(1, "R3/R6", {tag, " waveform"}, 0, 0);
    chk(rd_data == ref_crc(n), "R10/R6", {tag, " rd_data crc"}, rd_data, ref_crc(n));
    chk(eod_fall_ok, "R7", {tag, " eod clears at crc start"}, eod_fall_ok, 1);
    chk(irq_viol == 0, "R5", {tag, " irq masked by eod"}, irq_viol, 0);
    if (n >= 2) chk(irq_seen > 0, "R5", {tag, " irq raised"}, irq_seen, 1);
    chk(!arb_lost && !tx_fault, "R8/R9", {tag, " no abort flags"},
        {arb_lost, tx_fault}, 0);
  endtask

  task automatic full_frame(input int n, input string tag);
    eod_fall_idx = 4 * n + 1;
    @(negedge clk); mon_en = 1'b1;
    feed(n, 1);
    while (!mon_done) @(negedge clk);
    check_frame(n, tag);
    @(negedge clk); mon_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    int cnt;
    seed = $urandom(32'h1850);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!bus_out && tdre && !eod_bit && !busy && !arb_lost && !tx_fault && !tdre_irq,
        "R1", "reset state", {bus_out, tdre, eod_bit, busy, arb_lost, tx_fault}, 6'b010000);
    // R7 eod set while idle ignored
    pulse_eod();
    @(negedge clk);
    chk(!eod_bit && !busy, "R7", "eod_set idle ignored", eod_bit, 0);

    // R2/R4/R10: bus held dominant, second write ignored
    intruder = 1'b1;
    msg[0] = 8'hA5;
    eod_fall_idx = 5;
    @(negedge clk); mon_en = 1'b1;
    wr(8'hA5);
    chk(!tdre && busy, "R4", "tdre falls on write", tdre, 0);
    chk(rd_data == 8'h00, "R10", "rd_data not cpu byte", rd_data, 0);
    wr(8'h3C);
    pulse_eod();
    chk(eod_bit, "R7", "eod set while busy", eod_bit, 1);
    repeat (20) @(negedge clk);
    chk(!bus_out, "R2", "no sof while bus dominant", bus_out, 0);
    intruder = 1'b0;
    cnt = 0;
    while (!bus_out && cnt < 100) begin @(negedge clk); cnt++; end
    chk(cnt == IDLE_T + 1, "R2", "sof delay after release", cnt, IDLE_T + 1);
    while (!mon_done) @(negedge clk);
    check_frame(1, "R4 ignored write");
    @(negedge clk); mon_en = 1'b0;
    @(negedge clk);

    // directed patterns
    msg[0] = 8'h00; msg[1] = 8'hFF;
    full_frame(2, "R3 zero/ones");
    msg[0] = 8'h31; msg[1] = 8'h32; msg[2] = 8'h33;
    full_frame(3, "R6 ascii");

    // random frames
    for (int f = 0; f < 10; f++) begin
      int n;
      n = 1 + ($urandom % 8);
      for (int i = 0; i < n; i++) msg[i] = 8'($urandom);
      full_frame(n, "R3 random");
    end

    // R11 long frame
    for (int i = 0; i < 20; i++) msg[i] = 8'($urandom);
    full_frame(20, "R11 long frame");

    // R8 arbitration loss in first passive bit
    wr(8'h80);
    pulse_eod();
    while (!bus_out) @(negedge clk);
    while (bus_out) @(negedge clk);
    intruder = 1'b1;
    @(negedge clk);
    chk(arb_lost && !busy && !bus_out && !eod_bit && tdre && !tx_fault, "R8",
        "arbitration abort", {arb_lost, busy, bus_out, eod_bit, tdre, tx_fault}, 6'b100010);
    intruder = 1'b0;
    repeat (3) @(negedge clk);

    // R9 drive fault during start symbol
    wr(8'h55);
    chk(!arb_lost, "R8", "flag cleared by new frame", arb_lost, 0);
    while (!bus_out) @(negedge clk);
    force_low = 1'b1;
    @(negedge clk);
    chk(tx_fault && !busy && !bus_out && !arb_lost, "R9", "drive fault abort",
        {tx_fault, busy, bus_out, arb_lost}, 4'b1000);
    force_low = 1'b0;
    repeat (3) @(negedge clk);

    // R9 underrun: one byte without eod
    wr(8'hC3);
    chk(!tx_fault, "R9", "fault cleared by new frame", tx_fault, 0);
    cnt = 0;
    while (busy && cnt < 1000) begin @(negedge clk); cnt++; end
    chk(tx_fault && !arb_lost && !bus_out, "R9", "underrun abort",
        {tx_fault, arb_lost, bus_out}, 3'b100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule